// File: doc/BRIEF.md
# Non-Volatile Trim Register Controller

This block keeps an 8-bit trim code that drives a DAC. A pulse qualifier outside the block supplies single-cycle up and down events, and a single-cycle store request. The block applies these only while its enable input is high. The code saturates at both ends of its range and never wraps.

A store request copies the live code into a non-volatile memory. Recall runs the other way: it loads the register from that memory when reset releases and again whenever the enable falls. The memory sits behind a simple request/write/busy/read-data handshake. Program and recall each hold the controller busy until two things are true: a local timer has run out, and the memory has dropped its own busy signal.

To guard against a false count, the first qualified pulse after the enable rises is thrown away. The same applies to the first pulse after each store. Counting is also held off for a short start delay after the enable rises.

The controller is a seven-state machine:
- FETCH issues a read request. It is also the reset state.
- RECALL waits for the recall timer and the memory, then loads the code.
- IDLE is the disabled state.
- SETTLE runs the start delay after the enable rises.
- ARMED waits to discard the first pulse.
- ADJUST applies counts.
- PROGRAM waits out a write.

The transitions are:
- FETCH goes to RECALL unconditionally.
- RECALL goes to IDLE once the recall completes.
- IDLE goes to SETTLE when the enable is high.
- SETTLE goes to ARMED when the delay expires.
- ARMED goes to ADJUST on any up or down pulse.
- ARMED and ADJUST go to PROGRAM on a store request.
- PROGRAM goes to ARMED when the write completes and the enable is still high, or to FETCH when the enable is low.
- SETTLE, ARMED and ADJUST all go to FETCH when the enable is low.

Top module: `trim_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, `dac_code_o` is 0 and `busy_o` is 1. A recall follows on its own, and the code then equals the stored value (0x80 in a fresh memory).
- R2: In the adjust state, an up pulse adds 1 and a down pulse subtracts 1. Up and down in the same cycle leave the code unchanged. Outside a recall, the code never moves by more than 1 per cycle.
- R3: The code stops at 255 on up pulses and at 0 on down pulses, with no wrap.
- R4: After the enable rises and the start delay has passed, the first up or down pulse is discarded.
- R5: For START_CYC cycles after the enable rises, pulses are discarded, and they do not use up the R4 discard.
- R6: A store request while enabled writes the current code to memory. `busy_o` stays high for at least PROG_CYC cycles. The first pulse after the store is discarded. A store request takes priority over an up or down pulse in the same cycle.
- R7: When the enable falls, a recall starts and `busy_o` rises. `dac_code_o` keeps its old value until the recall completes, then takes the stored value.
- R8: While the enable is low, up, down and store requests have no effect on the code or on the stored value.
- R9: While `busy_o` is high, up and down pulses are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Adjustment enable; a falling edge forces a recall |
| up_i | input | 1 | Qualified up pulse, one cycle |
| dn_i | input | 1 | Qualified down pulse, one cycle |
| prog_i | input | 1 | Qualified store request, one cycle |
| nv_req_o | output | 1 | Memory request strobe, one cycle |
| nv_wr_o | output | 1 | With nv_req_o: 1 = write, 0 = read |
| nv_wdata_o | output | 8 | Data to write (the current code) |
| nv_busy_i | input | 1 | Memory busy |
| nv_rdata_i | input | 8 | Read data, valid once nv_busy_i is low |
| dac_code_o | output | 8 | Trim code driving the DAC |
| busy_o | output | 1 | A recall or program is in progress |

## Verification
The hardest situation to reach is a pulse that arrives while the start delay is still running, followed by the first pulse after the delay. Both must be discarded before any count lands. The stimulus raises the enable, sends an up pulse on the next cycle, waits out the delay, and then checks that two more pulses produce a net change of only one.

The pulses that arrive in the middle of a store are a second hard case. The stimulus injects an up pulse two cycles after the request, while the write is still busy. It then confirms that neither that pulse nor the next post-store pulse moves the code. Constrained-random up/down/both mixes run between these directed points, with store or no store chosen at random before each enable drop.

// File: rtl/trim_pkg.sv
package trim_pkg;

    typedef enum logic [2:0] {
        ST_FETCH   = 3'd0,
        ST_RECALL  = 3'd1,
        ST_IDLE    = 3'd2,
        ST_SETTLE  = 3'd3,
        ST_ARMED   = 3'd4,
        ST_ADJUST  = 3'd5,
        ST_PROGRAM = 3'd6
    } trim_state_e;

endpackage

// File: rtl/trim_sat_counter.sv
module trim_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         inc_i,
    input  logic         dec_i,
    output logic [W-1:0] q_o
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] MINV = '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_o <= MINV;
        end else if (load_i) begin
            q_o <= load_val_i;
        end else if (inc_i && !dec_i && q_o != MAXV) begin
            q_o <= q_o + 1'b1;
        end else if (dec_i && !inc_i && q_o != MINV) begin
            q_o <= q_o - 1'b1;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q_o) == MAXV && !$past(load_i)) |-> (q_o != MINV)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q_o) == MINV && !$past(load_i)) |-> (q_o != MAXV)); // R3

endmodule

// File: rtl/trim_timer.sv
module trim_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] val_i,
    output logic          done_o
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load_i) begin
            cnt <= val_i;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done_o = (cnt == '0);

endmodule

// File: rtl/trim_fsm.sv
module trim_fsm
    import trim_pkg::*;
#(
    parameter int TW         = 8,
    parameter int PROG_CYC   = 100,
    parameter int RECALL_CYC = 10,
    parameter int START_CYC  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable_i,
    input  logic          up_i,
    input  logic          dn_i,
    input  logic          prog_i,
    input  logic          nv_busy_i,
    input  logic          tmr_done_i,
    output logic          nv_req_o,
    output logic          nv_wr_o,
    output logic          tmr_load_o,
    output logic [TW-1:0] tmr_val_o,
    output logic          cnt_load_o,
    output logic          cnt_inc_o,
    output logic          cnt_dec_o,
    output logic          busy_o
);
    localparam logic [TW-1:0] T_PROG   = TW'(PROG_CYC);
    localparam logic [TW-1:0] T_RECALL = TW'(RECALL_CYC);
    localparam logic [TW-1:0] T_START  = TW'(START_CYC);

    trim_state_e state, nxt;
    logic        live;
    logic        store_go;
    logic        op_done;

    assign live     = (state == ST_ARMED) || (state == ST_ADJUST);
    assign store_go = live && enable_i && prog_i;
    assign op_done  = tmr_done_i && !nv_busy_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FETCH:   nxt = ST_RECALL;
            ST_RECALL:  if (op_done) nxt = ST_IDLE;
            ST_IDLE:    if (enable_i) nxt = ST_SETTLE;
            ST_SETTLE: begin
                if (!enable_i)       nxt = ST_FETCH;
                else if (tmr_done_i) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (!enable_i)         nxt = ST_FETCH;
                else if (prog_i)       nxt = ST_PROGRAM;
                else if (up_i || dn_i) nxt = ST_ADJUST;
            end
            ST_ADJUST: begin
                if (!enable_i)   nxt = ST_FETCH;
                else if (prog_i) nxt = ST_PROGRAM;
            end
            ST_PROGRAM: begin
                if (op_done) nxt = enable_i ? ST_ARMED : ST_FETCH;
            end
            default: nxt = ST_FETCH;
        endcase
    end

    always_comb begin
        nv_req_o   = 1'b0;
        nv_wr_o    = 1'b0;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        cnt_load_o = 1'b0;
        cnt_inc_o  = 1'b0;
        cnt_dec_o  = 1'b0;
        busy_o     = 1'b0;
        unique case (state)
            ST_FETCH: begin
                nv_req_o   = 1'b1;
                tmr_load_o = 1'b1;
                tmr_val_o  = T_RECALL;
                busy_o     = 1'b1;
            end
            ST_RECALL: begin
                busy_o     = 1'b1;
                cnt_load_o = op_done;
            end
            ST_IDLE: begin
                tmr_load_o = enable_i;
                tmr_val_o  = T_START;
            end
            ST_SETTLE: ;
            ST_ARMED, ST_ADJUST: begin
                if (store_go) begin
                    nv_req_o   = 1'b1;
                    nv_wr_o    = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = T_PROG;
                end
                if (state == ST_ADJUST && enable_i && !prog_i) begin
                    cnt_inc_o = up_i;
                    cnt_dec_o = dn_i;
                end
            end
            ST_PROGRAM: busy_o = 1'b1;
            default: busy_o = 1'b1;
        endcase
    end

    AST_BUSY_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!cnt_inc_o && !cnt_dec_o)); // R9
    AST_LOAD_ONLY_RECALL: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load_o |-> busy_o); // R7

endmodule

// File: rtl/trim_ctrl.sv
module trim_ctrl #(
    parameter int W          = 8,
    parameter int PROG_CYC   = 100000,
    parameter int RECALL_CYC = 10000,
    parameter int START_CYC  = 50
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         enable_i,
    input  logic         up_i,
    input  logic         dn_i,
    input  logic         prog_i,
    output logic         nv_req_o,
    output logic         nv_wr_o,
    output logic [W-1:0] nv_wdata_o,
    input  logic         nv_busy_i,
    input  logic [W-1:0] nv_rdata_i,
    output logic [W-1:0] dac_code_o,
    output logic         busy_o
);
    localparam int MAX_T = (PROG_CYC > RECALL_CYC)
                         ? ((PROG_CYC > START_CYC) ? PROG_CYC : START_CYC)
                         : ((RECALL_CYC > START_CYC) ? RECALL_CYC : START_CYC);
    localparam int TW = $clog2(MAX_T + 1);

    logic          tmr_load, tmr_done;
    logic [TW-1:0] tmr_val;
    logic          cnt_load, cnt_inc, cnt_dec;
    logic [W-1:0]  code;

    trim_fsm #(
        .TW(TW), .PROG_CYC(PROG_CYC), .RECALL_CYC(RECALL_CYC), .START_CYC(START_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
        .up_i(up_i), .dn_i(dn_i), .prog_i(prog_i),
        .nv_busy_i(nv_busy_i), .tmr_done_i(tmr_done),
        .nv_req_o(nv_req_o), .nv_wr_o(nv_wr_o),
        .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
        .cnt_load_o(cnt_load), .cnt_inc_o(cnt_inc), .cnt_dec_o(cnt_dec),
        .busy_o(busy_o)
    );

    trim_timer #(.TW(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
    );

    trim_sat_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_i(cnt_load), .load_val_i(nv_rdata_i),
        .inc_i(cnt_inc), .dec_i(cnt_dec), .q_o(code)
    );

    assign dac_code_o = code;
    assign nv_wdata_o = code;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(busy_o) |-> (dac_code_o == $past(dac_code_o)
                         || dac_code_o == W'($past(dac_code_o) + 1'b1)
                         || dac_code_o == W'($past(dac_code_o) - 1'b1))); // R2
    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(enable_i) && !$past(busy_o)) |-> $stable(dac_code_o)); // R8
    AST_WRITE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (nv_req_o && nv_wr_o) |-> enable_i); // R6
    AST_BUSY_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        nv_req_o |=> busy_o); // R7

endmodule

// File: tb/sim_trim_ctrl.sv
module sim_trim_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_C     = 40;
    localparam int RECALL_C   = 12;
    localparam int START_C    = 6;
    localparam int NV_LAT     = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable_i = 1'b0, up_i = 1'b0, dn_i = 1'b0, prog_i = 1'b0;
    logic       nv_req_o, nv_wr_o, nv_busy_i, busy_o;
    logic [7:0] nv_wdata_o, nv_rdata_i, dac_code_o;

    int tests = 0;
    int fails = 0;
    logic [7:0] exp_code, exp_mem;
    bit         discard_next;

    always #(CLK_PERIOD/2) clk = ~clk;

    // memory model
    logic [7:0] mem = 8'h80;
    logic [7:0] rd  = 8'h00;
    int         bcnt = 0;
    always @(posedge clk) begin
        if (nv_req_o) begin
            if (nv_wr_o) mem <= nv_wdata_o;
            else         rd  <= mem;
            bcnt <= NV_LAT;
        end else if (bcnt != 0) begin
            bcnt <= bcnt - 1;
        end
    end
    assign nv_busy_i  = (bcnt != 0);
    assign nv_rdata_i = rd;

    trim_ctrl #(.W(8), .PROG_CYC(PROG_C), .RECALL_CYC(RECALL_C), .START_CYC(START_C)) u0 (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i),
        .up_i(up_i), .dn_i(dn_i), .prog_i(prog_i),
        .nv_req_o(nv_req_o), .nv_wr_o(nv_wr_o), .nv_wdata_o(nv_wdata_o),
        .nv_busy_i(nv_busy_i), .nv_rdata_i(nv_rdata_i),
        .dac_code_o(dac_code_o), .busy_o(busy_o)
    );

    function automatic logic [7:0] sat_step(input logic [7:0] v, input bit u, input bit d);
        if (u && !d) return (v == 8'hFF) ? v : v + 8'd1;
        if (d && !u) return (v == 8'h00) ? v : v - 8'd1;
        return v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 2000 && busy_o; i++) tick(1);
    endtask

    // kind: 0 up, 1 down, 2 both
    task automatic send(input int kind, input bit modeled);
        up_i = (kind == 0 || kind == 2);
        dn_i = (kind == 1 || kind == 2);
        tick(1);
        up_i = 1'b0; dn_i = 1'b0;
        tick(2);
        if (modeled) begin
            if (discard_next) discard_next = 1'b0;
            else exp_code = sat_step(exp_code, kind != 1, kind != 0);
        end
    endtask

    task automatic enable_on();
        enable_i = 1'b1;
        tick(START_C + 4);
        discard_next = 1'b1;
    endtask

    task automatic enable_off(input string req);
        enable_i = 1'b0;
        tick(3);
        check(req, busy_o, 1);
        check(req, dac_code_o, exp_code);  // old value held during recall
        wait_idle();
        exp_code = exp_mem;
        check(req, dac_code_o, exp_code);
    endtask

    task automatic store(input bit poke);
        int bc;
        prog_i = 1'b1;
        tick(1);
        prog_i = 1'b0;
        bc = 0;
        if (poke) begin
            tick(1); bc++;
            up_i = 1'b1; tick(1); up_i = 1'b0; bc++;   // R9: pulse while busy
        end
        for (int i = 0; i < 2000 && busy_o; i++) begin tick(1); bc++; end
        check("R6 busy length", (bc >= PROG_C) ? 1 : 0, 1);
        exp_mem = exp_code;
        discard_next = 1'b1;
        check("R9 no count while busy", dac_code_o, exp_code);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog all-R actual=hung expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        tick(3);
        check("R1 reset code", dac_code_o, 0);
        rst_n = 1'b1;
        tick(1);
        check("R1 busy after reset", busy_o, 1);
        check("R1 code before recall", dac_code_o, 0);
        wait_idle();
        exp_code = 8'h80; exp_mem = 8'h80;
        check("R1 power-up recall", dac_code_o, 8'h80);

        // R8: disabled, nothing moves
        send(0, 1'b0); send(1, 1'b0);
        prog_i = 1'b1; tick(1); prog_i = 1'b0; tick(3);
        check("R8 disabled pulses", dac_code_o, exp_code);
        check("R8 disabled no busy", busy_o, 0);

        // R5 / R4: pulse inside start delay, then first pulse discarded
        enable_i = 1'b1;
        tick(1);
        send(0, 1'b0);
        tick(START_C + 2);
        discard_next = 1'b1;
        send(0, 1'b1);
        check("R5 R4 pulses discarded", dac_code_o, 8'h80);
        send(0, 1'b1);
        check("R2 first counted up", dac_code_o, 8'h81);
        send(2, 1'b1);
        check("R2 up+down same cycle", dac_code_o, 8'h81);

        // R2 random walk
        for (int i = 0; i < 80; i++) begin
            send(int'($urandom % 3), 1'b1);
            check("R2 random step", dac_code_o, exp_code);
        end

        // R3 saturation
        for (int i = 0; i < 270; i++) send(0, 1'b1);
        check("R3 clamp high", dac_code_o, 8'hFF);
        for (int i = 0; i < 270; i++) send(1, 1'b1);
        check("R3 clamp low", dac_code_o, 8'h00);
        for (int i = 0; i < 48; i++) send(0, 1'b1);
        check("R2 ramp", dac_code_o, 8'h30);

        // R6 store, R9 pulse during busy
        store(1'b1);
        send(0, 1'b1);
        check("R6 first pulse after store ignored", dac_code_o, 8'h30);
        send(0, 1'b1);
        check("R6 count after store", dac_code_o, 8'h31);

        // R7 recall on enable fall
        enable_off("R7 recall");
        check("R7 recalled stored", dac_code_o, 8'h30);

        // R8 store request while disabled must not write
        prog_i = 1'b1; tick(1); prog_i = 1'b0; tick(2);
        enable_on();
        for (int i = 0; i < 6; i++) send(1, 1'b1);
        enable_off("R8 store ignored while disabled");

        // random rounds
        for (int r = 0; r < 4; r++) begin
            enable_on();
            for (int i = 0; i < 25; i++) begin
                send(int'($urandom % 3), 1'b1);
                check("R2 round step", dac_code_o, exp_code);
            end
            if ($urandom % 2) begin
                store(1'b0);
                send(0, 1'b1);
                check("R6 round discard", dac_code_o, exp_code);
            end
            enable_off("R7 round recall");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule